// File: doc/BRIEF.md
# Word-Window Transfer Buffer

This block holds the payload of one serial memory transaction in a 512-byte store. Software sees the store as 128 words of 32 bits and reaches them through a single data window register. A control register picks which way the host moves data (filling the store before an outgoing transfer, or emptying it after an incoming one), switches on automatic advance of the word index, and loads that index. When automatic advance is on, each window access that matches the programmed direction moves the index to the next word, so a whole payload can be streamed through one register address.

The serial sequencer reaches the same store one byte at a time through its own byte pointer. Software sets that pointer, normally to zero, through a third register before each transfer. Bytes are packed little-endian inside a word: byte pointer bits [1:0] pick the lane and the bits above them pick the word. A payload whose length is not a multiple of four therefore ends with one full-word host access, of which the sequencer uses only the low lanes. The host side always wins a same-cycle clash with the sequencer. A rejected sequencer request is simply retried.

Top module: `xfer_buf_top`

## Requirements
- R1: After reset the direction bit, the advance bit, the word index, the byte pointer, `host_rdata` and `seq_rbyte` are all zero.
- R2: A host write to the control register (offset 0x240) loads the direction from bit 31 (1 = host fills, 0 = host empties), the advance enable from bit 30, and the word index from bits 6:0. Bit 7 of the index field is ignored. A read of that register returns the same fields at the same positions, with every other bit zero.
- R3: With direction 1, a window write (offset 0x244) stores the 32-bit word at the current index. With direction 0, a window read returns the word at the current index.
- R4: With the advance enable set, each window access that matches the direction moves the index up by one, and index 127 is followed by 0. With it clear, the index does not change.
- R5: A window access against the direction is ignored: a write stores nothing, a read returns zero, and the index does not move.
- R6: A host write to the pointer register (offset 0x248) loads the byte pointer from bits 8:0, and a read returns the pointer in bits 8:0 with the upper bits zero.
- R7: An accepted sequencer request writes `seq_wbyte` into, or reads into `seq_rbyte` from, the byte at the pointer (lane = pointer[1:0], bits 8*lane+7..8*lane; word = pointer[8:2]). Other bytes are left unchanged. The pointer then moves up by one, and 511 is followed by 0.
- R8: `seq_ack` is low in any cycle in which the host accesses the window or the pointer register. A rejected request changes neither the store nor the pointer.
- R9: `host_rdata` shows the result of a host read in the cycle after the access and holds it until the next host read. `seq_rbyte` likewise holds the last accepted sequencer read. A read from an unmapped offset returns zero, and a write to one has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | Host access this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 12 | Register offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid the cycle after a read |
| seq_req | input | 1 | Sequencer byte request |
| seq_wr | input | 1 | 1 = byte write, 0 = byte read |
| seq_wbyte | input | 8 | Byte to store |
| seq_ack | output | 1 | Request accepted this cycle |
| seq_rbyte | output | 8 | Byte read, valid the cycle after an accepted read |

## Verification
The assertions assume single-cycle host accesses with `host_wr` and `host_addr` steady while `host_sel` is high, and a sequencer that keeps its request fields steady within the cycle. The stimulus drives every input on the falling clock edge, and all randomized host and sequencer operations are drawn from those legal single-cycle forms. Before any read, the bench writes every word once, so no assertion or check ever sees an uninitialized location. It brings host and sequencer together in a single cycle only in the directed arbitration case.

// File: rtl/xfer_buf_pkg.sv
`timescale 1ns/1ps
package xfer_buf_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned LANE_W   = 8;
  localparam int unsigned OFS_W    = 12;
  localparam logic [OFS_W-1:0] OFS_CTRL = 12'h240;
  localparam logic [OFS_W-1:0] OFS_WIN  = 12'h244;
  localparam logic [OFS_W-1:0] OFS_PTR  = 12'h248;

  typedef enum logic [1:0] {HIT_NONE, HIT_CTRL, HIT_WIN, HIT_PTR} hit_e;

  function automatic hit_e decode(input logic [OFS_W-1:0] a);
    if (a == OFS_CTRL) return HIT_CTRL;
    if (a == OFS_WIN)  return HIT_WIN;
    if (a == OFS_PTR)  return HIT_PTR;
    return HIT_NONE;
  endfunction

  function automatic logic [REG_W-1:0] put_lane(input logic [REG_W-1:0] w,
                                                input logic [1:0] lane,
                                                input logic [LANE_W-1:0] b);
    logic [REG_W-1:0] r;
    r = w;
    r[{lane, 3'b000} +: LANE_W] = b;
    return r;
  endfunction

  function automatic logic [LANE_W-1:0] get_lane(input logic [REG_W-1:0] w,
                                                 input logic [1:0] lane);
    return w[{lane, 3'b000} +: LANE_W];
  endfunction
endpackage

// File: rtl/xfer_buf_regs.sv
`timescale 1ns/1ps
module xfer_buf_regs #(
  parameter int unsigned IDX_W = 7,
  parameter int unsigned PTR_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             dir_in,
  input  logic             adv_in,
  input  logic [IDX_W-1:0] idx_in,
  input  logic             win_go,
  input  logic             ptr_wr,
  input  logic [PTR_W-1:0] ptr_in,
  input  logic             seq_go,
  output logic             dir_q,
  output logic             adv_q,
  output logic [IDX_W-1:0] idx_q,
  output logic [PTR_W-1:0] ptr_q
);
  localparam logic [IDX_W-1:0] IDX_ONE = {{(IDX_W-1){1'b0}}, 1'b1};
  localparam logic [PTR_W-1:0] PTR_ONE = {{(PTR_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      adv_q <= 1'b0;
      idx_q <= '0;
    end else if (ctrl_wr) begin
      dir_q <= dir_in;
      adv_q <= adv_in;
      idx_q <= idx_in;
    end else if (win_go && adv_q) begin
      idx_q <= idx_q + IDX_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_wr) ptr_q <= ptr_in;
    else if (seq_go) ptr_q <= ptr_q + PTR_ONE;
  end

  // R4
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && !(win_go && adv_q)) |=> $stable(idx_q));
  // R6
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> ptr_q == $past(ptr_in));
  // R7
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_wr && !seq_go) |=> $stable(ptr_q));
endmodule

// File: rtl/xfer_buf_arb.sv
`timescale 1ns/1ps
module xfer_buf_arb (
  input  logic host_claim,
  input  logic seq_req,
  output logic seq_go
);
  assign seq_go = seq_req & ~host_claim;
endmodule

// File: rtl/xfer_buf_store.sv
`timescale 1ns/1ps
module xfer_buf_store
  import xfer_buf_pkg::*;
#(
  parameter int unsigned WORDS = 128,
  parameter int unsigned IDX_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_we,
  input  logic              h_re,
  input  logic [IDX_W-1:0]  h_idx,
  input  logic [REG_W-1:0]  h_wdata,
  output logic [REG_W-1:0]  h_q,
  input  logic              s_we,
  input  logic              s_re,
  input  logic [IDX_W-1:0]  s_word,
  input  logic [1:0]        s_lane,
  input  logic [LANE_W-1:0] s_wbyte,
  output logic [LANE_W-1:0] s_q
);
  logic [REG_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (h_we)      mem[h_idx]  <= h_wdata;
    else if (s_we) mem[s_word] <= put_lane(mem[s_word], s_lane, s_wbyte);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0;
      s_q <= '0;
    end else begin
      if (h_re) h_q <= mem[h_idx];
      if (s_re) s_q <= get_lane(mem[s_word], s_lane);
    end
  end

  // R8
  one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_we && s_we));
endmodule

// File: rtl/xfer_buf_top.sv
`timescale 1ns/1ps
module xfer_buf_top
  import xfer_buf_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [OFS_W-1:0]  host_addr,
  input  logic [REG_W-1:0]  host_wdata,
  output logic [REG_W-1:0]  host_rdata,
  input  logic              seq_req,
  input  logic              seq_wr,
  input  logic [LANE_W-1:0] seq_wbyte,
  output logic              seq_ack,
  output logic [LANE_W-1:0] seq_rbyte
);
  localparam int unsigned WORDS = BUF_BYTES / (REG_W / LANE_W);
  localparam int unsigned IDX_W = $clog2(WORDS);
  localparam int unsigned PTR_W = $clog2(BUF_BYTES);

  hit_e hit;
  logic ctrl_wr, ptr_wr, win_wr_ok, win_rd_ok, win_bad_rd, win_go, host_claim, seq_go;
  logic dir_q, adv_q;
  logic [IDX_W-1:0] idx_q;
  logic [PTR_W-1:0] ptr_q;
  logic [REG_W-1:0] store_q, regs_val, regs_q;
  logic             win_src_q;

  assign hit        = host_sel ? decode(host_addr) : HIT_NONE;
  assign ctrl_wr    = (hit == HIT_CTRL) && host_wr;
  assign ptr_wr     = (hit == HIT_PTR) && host_wr;
  assign win_wr_ok  = (hit == HIT_WIN) && host_wr && dir_q;
  assign win_rd_ok  = (hit == HIT_WIN) && !host_wr && !dir_q;
  assign win_bad_rd = (hit == HIT_WIN) && !host_wr && dir_q;
  assign win_go     = win_wr_ok || win_rd_ok;
  assign host_claim = (hit == HIT_WIN) || (hit == HIT_PTR);

  xfer_buf_regs #(.IDX_W(IDX_W), .PTR_W(PTR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(ctrl_wr), .dir_in(host_wdata[31]), .adv_in(host_wdata[30]),
    .idx_in(host_wdata[IDX_W-1:0]), .win_go(win_go),
    .ptr_wr(ptr_wr), .ptr_in(host_wdata[PTR_W-1:0]), .seq_go(seq_go),
    .dir_q(dir_q), .adv_q(adv_q), .idx_q(idx_q), .ptr_q(ptr_q)
  );

  xfer_buf_arb u_arb (.host_claim(host_claim), .seq_req(seq_req), .seq_go(seq_go));

  xfer_buf_store #(.WORDS(WORDS), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .h_we(win_wr_ok), .h_re(win_rd_ok), .h_idx(idx_q), .h_wdata(host_wdata), .h_q(store_q),
    .s_we(seq_go && seq_wr), .s_re(seq_go && !seq_wr),
    .s_word(ptr_q[PTR_W-1:2]), .s_lane(ptr_q[1:0]), .s_wbyte(seq_wbyte), .s_q(seq_rbyte)
  );

  always_comb begin
    regs_val = '0;
    if (hit == HIT_CTRL) begin
      regs_val[31]          = dir_q;
      regs_val[30]          = adv_q;
      regs_val[IDX_W-1:0]   = idx_q;
    end else if (hit == HIT_PTR) begin
      regs_val[PTR_W-1:0]   = ptr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q    <= '0;
      win_src_q <= 1'b0;
    end else if (host_sel && !host_wr) begin
      regs_q    <= regs_val;
      win_src_q <= win_rd_ok;
    end
  end

  assign host_rdata = win_src_q ? store_q : regs_q;
  assign seq_ack    = seq_go;

  // R5
  bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_bad_rd |=> host_rdata == '0);
  // R8
  host_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && (host_addr == OFS_WIN || host_addr == OFS_PTR)) |-> !seq_ack);
  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_sel && !host_wr) |=> $stable(host_rdata));
endmodule

// File: tb/xfer_buf_top_tb.sv
`timescale 1ns/1ps
module xfer_buf_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0, host_wr = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        seq_req = 1'b0, seq_wr = 1'b0;
  logic [7:0]  seq_wbyte = '0;
  logic        seq_ack;
  logic [7:0]  seq_rbyte;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_mem [128];
  bit          m_dir, m_adv;
  int          m_idx, m_ptr;

  always #5 clk = ~clk;

  xfer_buf_top u_dut (.*);

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic int next_word(input int i);
    return (i + 1) % 128;
  endfunction

  function automatic logic [31:0] ctrl_image();
    return {m_dir, m_adv, 23'd0, m_idx[6:0]};
  endfunction

  task automatic host(input bit wr, input logic [11:0] a, input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    host_sel = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 1'b0;
    q = host_rdata;
  endtask

  task automatic seq(input bit wr, input logic [7:0] b, output bit ack, output logic [7:0] q);
    @(negedge clk);
    seq_req = 1'b1; seq_wr = wr; seq_wbyte = b;
    #1 ack = seq_ack;
    @(negedge clk);
    seq_req = 1'b0;
    q = seq_rbyte;
  endtask

  task automatic m_win(input bit wr, input logic [31:0] d, output logic [31:0] exp);
    exp = 32'd0;
    if (wr == m_dir) begin
      if (wr) m_mem[m_idx] = d; else exp = m_mem[m_idx];
      if (m_adv) m_idx = next_word(m_idx);
    end
  endtask

  task automatic m_seq(input bit wr, input logic [7:0] b, output logic [7:0] exp);
    int w, l;
    w = m_ptr / 4; l = m_ptr % 4;
    exp = m_mem[w][8*l +: 8];
    if (wr) m_mem[w][8*l +: 8] = b;
    m_ptr = (m_ptr + 1) % 512;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] q, e;
    logic [7:0]  bq, be;
    bit          ack;
    void'($urandom(32'h1234_5a5a));
    m_dir = 0; m_adv = 0; m_idx = 0; m_ptr = 0;
    repeat (3) @(negedge clk);
    // R1 reset state at ports
    check("R1 rdata", host_rdata, 0);
    check("R1 rbyte", {24'd0, seq_rbyte}, 0);
    rst_n = 1'b1;
    host(0, 12'h240, 0, q); check("R1 ctrl", q, 0);
    host(0, 12'h248, 0, q); check("R1 ptr", q, 0);

    // R2 bit 7 of index ignored, fields read back
    host(1, 12'h240, 32'hC000_00FF, q);
    m_dir = 1; m_adv = 1; m_idx = 127;
    host(0, 12'h240, 0, q); check("R2 ctrl readback", q, ctrl_image());
    // R3 R4 fill all words starting at 127, wraps to 0
    for (int i = 0; i < 128; i++) begin
      logic [31:0] d;
      d = $urandom;
      host(1, 12'h244, d, q); m_win(1, d, e);
    end
    host(0, 12'h240, 0, q); check("R4 wrap after full pass", q, ctrl_image());

    // R5 read against direction returns 0, index unmoved
    host(0, 12'h244, 0, q); m_win(0, 0, e); check("R5 bad read", q, e);
    host(0, 12'h240, 0, q); check("R5 index held", q, ctrl_image());

    // R3 drain, advance off
    host(1, 12'h240, 32'h0000_0005, q); m_dir = 0; m_adv = 0; m_idx = 5;
    host(0, 12'h244, 0, q); m_win(0, 0, e); check("R3 read", q, e);
    host(0, 12'h244, 0, q); m_win(0, 0, e); check("R4 no advance", q, e);
    // R5 write against direction ignored
    host(1, 12'h244, 32'hDEAD_BEEF, q); m_win(1, 32'hDEAD_BEEF, e);
    host(0, 12'h244, 0, q); m_win(0, 0, e); check("R5 write ignored", q, e);

    // R9 unmapped
    host(1, 12'h100, 32'hFFFF_FFFF, q);
    host(0, 12'h100, 0, q); check("R9 unmapped read", q, 0);
    host(0, 12'h240, 0, q); check("R9 unmapped write", q, ctrl_image());
    repeat (3) @(negedge clk);
    check("R9 hold", host_rdata, ctrl_image());

    // R7 pointer wrap 511 -> 0
    host(1, 12'h248, 32'hFFFF_FDFF, q); m_ptr = 511;
    host(0, 12'h248, 0, q); check("R6 ptr load", q, 511);
    seq(0, 0, ack, bq); m_seq(0, 0, be);
    check("R7 ack", {31'd0, ack}, 1); check("R7 byte", {24'd0, bq}, {24'd0, be});
    host(0, 12'h248, 0, q); check("R7 ptr wrap", q, 0);

    // R8 host and sequencer in the same cycle
    @(negedge clk);
    host_sel = 1; host_wr = 0; host_addr = 12'h244; seq_req = 1; seq_wr = 1; seq_wbyte = 8'h5A;
    #1 check("R8 ack low", {31'd0, seq_ack}, 0);
    @(negedge clk);
    host_sel = 0; seq_req = 0; q = host_rdata;
    m_win(0, 0, e); check("R8 host read", q, e);
    host(0, 12'h248, 0, q); check("R8 ptr unchanged", q, m_ptr);
    seq(0, 0, ack, bq); m_seq(0, 0, be); check("R8 byte unchanged", {24'd0, bq}, {24'd0, be});

    // random mix
    for (int k = 0; k < 700; k++) begin
      int op;
      op = $urandom % 7;
      case (op)
        0: begin
          logic [31:0] d;
          d = $urandom;
          host(1, 12'h240, d, q);
          m_dir = d[31]; m_adv = d[30]; m_idx = d[6:0];
          host(0, 12'h240, 0, q); check("R2 ctrl", q, ctrl_image());
        end
        1, 2: begin
          logic [31:0] d;
          d = $urandom;
          host(1, 12'h244, d, q); m_win(1, d, e);
        end
        3: begin
          host(0, 12'h244, 0, q); m_win(0, 0, e);
          check(m_dir ? "R5 window read" : "R3 window read", q, e);
        end
        4, 5: begin
          bit w;
          logic [7:0] b;
          w = $urandom % 2; b = $urandom;
          seq(w, b, ack, bq); m_seq(w, b, be);
          check("R7 ack", {31'd0, ack}, 1);
          if (!w) check("R7 seq read", {24'd0, bq}, {24'd0, be});
        end
        default: begin
          logic [31:0] d;
          d = $urandom;
          host(1, 12'h248, d, q); m_ptr = d[8:0];
          host(0, 12'h248, 0, q); check("R6 ptr", q, m_ptr);
        end
      endcase
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule